// File: doc/BRIEF.md
# UART Receiver with Shared Framing-Error / Line-Activity Flag

This block receives asynchronous serial frames on a single RX line. A clock-enable input marks each oversampling tick. The block checks the start bit at its middle and then samples each bit once at its centre. It assembles either 7 or 8 data bits, least significant bit first. When parity is enabled, the receiver captures one more bit after the last data bit. It checks one stop bit. If that stop bit is good, the block presents the byte and the captured parity bit and raises a one-cycle data-valid pulse to the next stage.

A single status bit serves two purposes. In normal operation it is a sticky framing-error flag. It is set when the stop position samples low, and it stays set until a correctly framed character arrives or the host strobes a configuration write. After a framing error the receiver drops the frame and goes back to hunting for a start bit.

In shutdown the receiver is held idle, and the same bit records line activity: any transition on RX sets it. A separate shutdown-clear strobe wipes the flag, the held data byte and the held parity bit.

The output interface has no back-pressure. `out_valid` is a single-cycle pulse with no ready input. `data_out` and `parity_out` stay stable from that pulse until the next good frame or a shutdown-clear strobe, so the consumer must take the data by then.

Top module: `uart_rx_flag`

## Requirements
- R1: After reset, `status_flag`, `data_out`, `parity_out` and `out_valid` are all 0.
- R2: A low level on RX becomes a start bit only if RX is still low OSR/2 ticks after the low is first seen. A shorter low pulse produces no frame and leaves the flag unchanged.
- R3: Data bits are sampled LSB first, each one OSR ticks after the previous sample. With `word7`=0, all 8 bits land in `data_out[7:0]`.
- R4: With `word7`=1, seven bits are received into `data_out[6:0]` and `data_out[7]` is 0.
- R5: With `parity_en`=1, the bit after the last data bit appears on `parity_out`. With `parity_en`=0, `parity_out` is 0 after a good frame.
- R6: A stop position sampled high gives exactly one `out_valid` cycle. The data then stays on `data_out` until the next good frame.
- R7: A stop position sampled low gives no `out_valid`, sets `status_flag` to 1, and returns the receiver to start-bit search. The flag stays set while the line idles.
- R8: In normal mode, a correctly framed character clears `status_flag`.
- R9: A `cfg_wr` strobe clears `status_flag` on the next cycle.
- R10: While `shutdown`=1, the receiver produces no `out_valid`, and any RX transition sets `status_flag` to 1.
- R11: A `shdn_clr` strobe clears `status_flag`, `data_out` and `parity_out` on the next cycle.
- R12: Only one stop bit is checked, so a frame may start immediately after a single stop bit and is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, OSR ticks per bit |
| rx | input | 1 | Asynchronous serial line, idle high |
| word7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| parity_en | input | 1 | 1 expects a parity bit after the data |
| shutdown | input | 1 | Shutdown mode level |
| cfg_wr | input | 1 | Configuration-write strobe, clears the flag |
| shdn_clr | input | 1 | Shutdown-clear strobe, clears flag, data and parity |
| data_out | output | 8 | Last good received byte |
| parity_out | output | 1 | Parity bit of the last good frame |
| out_valid | output | 1 | One-cycle pulse per good frame |
| status_flag | output | 1 | Framing error (normal mode) or line activity (shutdown) |

## Verification
The bench builds the block with OSR=8 and the default two-stage synchronizer, and holds `os_tick` high on every clock. Each bit then lasts eight clocks, so a full 11-bit frame takes under a hundred cycles. This lets the bench run many frames, back-to-back frames and shutdown sequences quickly. It also places the start-bit mid check four ticks after the falling edge, which makes the two-cycle glitch test show the false-start rejection directly.

// File: rtl/uart_rx_flag_pkg.sv
package uart_rx_flag_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  output logic rx_s,
  output logic rx_edge
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '1;
      prev <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], rx};
      prev <= pipe[STAGES-1];
    end
  end

  assign rx_s    = pipe[STAGES-1];
  assign rx_edge = pipe[STAGES-1] ^ prev;
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import uart_rx_flag_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              word7,
  input  logic              parity_en,
  input  logic              shutdown,
  input  logic              shdn_clr,
  output logic [DATA_W-1:0] data_o,
  output logic              par_o,
  output logic              valid_o,
  output logic              frame_ok,
  output logic              frame_err
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] HALF_C = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL_C = CW'(OSR - 1);

  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              pbit, m7, mp;
  logic [BW-1:0]     last_idx;

  assign last_idx = m7 ? BW'(DATA_W - 2) : BW'(DATA_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; idx <= '0; shreg <= '0;
      pbit <= 1'b0; m7 <= 1'b0; mp <= 1'b0;
      data_o <= '0; par_o <= 1'b0;
      valid_o <= 1'b0; frame_ok <= 1'b0; frame_err <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
      if (shutdown || shdn_clr) begin
        st  <= ST_IDLE;
        cnt <= '0;
        if (shdn_clr) begin
          data_o <= '0;
          par_o  <= 1'b0;
        end
      end else if (tick) begin
        case (st)
          ST_IDLE: if (!rx_s) begin
            st  <= ST_START;
            cnt <= '0;
          end
          ST_START: if (cnt == HALF_C) begin
            cnt <= '0;
            if (!rx_s) begin
              st <= ST_DATA; idx <= '0; shreg <= '0; pbit <= 1'b0;
              m7 <= word7; mp <= parity_en;
            end else begin
              st <= ST_IDLE;
            end
          end else cnt <= cnt + 1'b1;
          ST_DATA: if (cnt == FULL_C) begin
            cnt        <= '0;
            shreg[idx] <= rx_s;
            if (idx == last_idx) st <= mp ? ST_PAR : ST_STOP;
            else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
          ST_PAR: if (cnt == FULL_C) begin
            cnt  <= '0;
            pbit <= rx_s;
            st   <= ST_STOP;
          end else cnt <= cnt + 1'b1;
          ST_STOP: if (cnt == FULL_C) begin
            cnt <= '0;
            st  <= ST_IDLE;
            if (rx_s) begin
              data_o   <= shreg;
              par_o    <= mp & pbit;
              valid_o  <= 1'b1;
              frame_ok <= 1'b1;
            end else begin
              frame_err <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r10_quiet_shdn: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !valid_o);
  a_r4_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && m7) |-> !data_o[DATA_W-1]);
  a_r7_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !valid_o);
endmodule

// File: rtl/rx_status_flag.sv
module rx_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic shutdown,
  input  logic rx_edge,
  input  logic frame_ok,
  input  logic frame_err,
  input  logic cfg_wr,
  input  logic shdn_clr,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else if (shdn_clr || cfg_wr) flag_o <= 1'b0;
    else if (shutdown) begin
      if (rx_edge) flag_o <= 1'b1;
    end
    else if (frame_err) flag_o <= 1'b1;
    else if (frame_ok) flag_o <= 1'b0;
  end

  a_r9_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !flag_o);
  a_r8_good_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !shutdown) |=> !flag_o);
  a_r7_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !shutdown && !cfg_wr && !shdn_clr) |=> flag_o);
  a_r10_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && rx_edge && !cfg_wr && !shdn_clr) |=> flag_o);
endmodule

// File: rtl/uart_rx_flag.sv
module uart_rx_flag #(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx,
  input  logic       word7,
  input  logic       parity_en,
  input  logic       shutdown,
  input  logic       cfg_wr,
  input  logic       shdn_clr,
  output logic [7:0] data_out,
  output logic       parity_out,
  output logic       out_valid,
  output logic       status_flag
);
  localparam int DATA_W = 8;

  logic rx_s, rx_edge, frame_ok, frame_err;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx(rx), .rx_s(rx_s), .rx_edge(rx_edge)
  );

  rx_framer #(.OSR(OSR), .DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s),
    .word7(word7), .parity_en(parity_en), .shutdown(shutdown),
    .shdn_clr(shdn_clr), .data_o(data_out), .par_o(parity_out),
    .valid_o(out_valid), .frame_ok(frame_ok), .frame_err(frame_err)
  );

  rx_status_flag u_flag (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .rx_edge(rx_edge),
    .frame_ok(frame_ok), .frame_err(frame_err), .cfg_wr(cfg_wr),
    .shdn_clr(shdn_clr), .flag_o(status_flag)
  );

  a_r11_shdn_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_clr |=> (!status_flag && data_out == 8'h00 && !parity_out));
endmodule

// File: tb/uart_rx_flag_test.sv
module uart_rx_flag_test;
  localparam int OSR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, word7 = 1'b0, parity_en = 1'b0, shutdown = 1'b0;
  logic cfg_wr = 1'b0, shdn_clr = 1'b0;
  logic [7:0] data_out;
  logic parity_out, out_valid, status_flag;

  int checks = 0, fails = 0, vcnt = 0;
  logic [7:0] seen_d = 8'h00;
  logic seen_p = 1'b0;

  always #5 clk = ~clk;

  uart_rx_flag #(.OSR(OSR), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .os_tick(1'b1), .rx(rx), .word7(word7),
    .parity_en(parity_en), .shutdown(shutdown), .cfg_wr(cfg_wr),
    .shdn_clr(shdn_clr), .data_out(data_out), .parity_out(parity_out),
    .out_valid(out_valid), .status_flag(status_flag)
  );

  always @(negedge clk) if (out_valid) begin
    vcnt++; seen_d = data_out; seen_p = parity_out;
  end

  typedef struct packed {
    logic [7:0] d; logic w7; logic pen; logic pb; logic stop;
    logic ev; logic [7:0] ed; logic ep; logic ef;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0},
    '{8'h3C, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0},
    '{8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h7F, 1'b0, 1'b0},
    '{8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    '{8'h12, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h12, 1'b0, 1'b0},
    '{8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    '{8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * OSR) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic w7, input logic pen,
                            input logic pb, input logic stop);
    rx = 1'b0; wait_bits(1);
    for (int i = 0; i < (w7 ? 7 : 8); i++) begin rx = d[i]; wait_bits(1); end
    if (pen) begin rx = pb; wait_bits(1); end
    rx = stop; wait_bits(1);
    rx = 1'b1;
  endtask

  task automatic pulse(input int which);
    if (which == 0) cfg_wr = 1'b1; else shdn_clr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; shdn_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flag", status_flag, 0);
    chk("R1 data", data_out, 0);
    chk("R1 parity", parity_out, 0);
    chk("R1 valid", out_valid, 0);
    rst_n = 1'b1;
    wait_bits(2);

    // vector table: R3 R4 R5 R6 R7 R8
    for (int k = 0; k < 7; k++) begin
      v0 = vcnt;
      word7 = VECS[k].w7; parity_en = VECS[k].pen;
      send_frame(VECS[k].d, VECS[k].w7, VECS[k].pen, VECS[k].pb, VECS[k].stop);
      wait_bits(3);
      chk("R6 R7 valid count", vcnt - v0, VECS[k].ev ? 1 : 0);
      if (VECS[k].ev) begin
        chk("R3 R4 data", seen_d, VECS[k].ed);
        chk("R5 parity", seen_p, VECS[k].ep);
        chk("R6 data held", data_out, VECS[k].ed);
      end
      chk("R7 R8 flag", status_flag, VECS[k].ef);
    end

    // R2 short low glitch is not a start bit
    v0 = vcnt;
    rx = 1'b0; repeat (2) @(negedge clk); rx = 1'b1;
    wait_bits(3);
    chk("R2 glitch no frame", vcnt - v0, 0);
    chk("R2 glitch flag", status_flag, 0);

    // R7 persistence, then R9 clear by configuration write
    word7 = 1'b0; parity_en = 1'b0;
    send_frame(8'h99, 1'b0, 1'b0, 1'b0, 1'b0);
    wait_bits(10);
    chk("R7 flag persists", status_flag, 1);
    pulse(0);
    chk("R9 cfg_wr clears", status_flag, 0);

    // R12 back-to-back with a single stop bit
    v0 = vcnt; parity_en = 1'b1;
    send_frame(8'h81, 1'b0, 1'b1, 1'b0, 1'b1);
    send_frame(8'hC3, 1'b0, 1'b1, 1'b1, 1'b1);
    wait_bits(3);
    chk("R12 two frames", vcnt - v0, 2);
    chk("R12 second data", seen_d, 8'hC3);
    chk("R12 second parity", seen_p, 1);

    // R10 shutdown activity flag and no output
    shutdown = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 no spurious flag", status_flag, 0);
    rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 activity sets flag", status_flag, 1);
    v0 = vcnt;
    send_frame(8'h5A, 1'b0, 1'b1, 1'b0, 1'b1);
    wait_bits(3);
    chk("R10 no valid in shutdown", vcnt - v0, 0);
    chk("R10 data untouched", data_out, 8'hC3);

    // R11 shutdown-clear wipes flag, data and parity
    pulse(1);
    chk("R11 flag", status_flag, 0);
    chk("R11 data", data_out, 0);
    chk("R11 parity", parity_out, 0);

    // back to normal: R3 frame received again
    shutdown = 1'b0; parity_en = 1'b0;
    wait_bits(1);
    v0 = vcnt;
    send_frame(8'h6E, 1'b0, 1'b0, 1'b0, 1'b1);
    wait_bits(3);
    chk("R3 after wake valid", vcnt - v0, 1);
    chk("R3 after wake data", data_out, 8'h6E);

    finish_run();
  end
endmodule